// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one data byte at a time into an asynchronous serial frame on a single line. An 8-bit mode register sets the frame format: 7-bit or 8-bit characters, an optional even or odd parity bit, one or two stop bits, and an optional address/data marker bit for multi-drop links. The same register also selects a clock prescaler of 1, 4, 16 or 64. A 16-bit divisor input sets how many prescaled ticks each bit lasts, so one bit takes (divisor + 1) × prescale system clocks.

A host writes the mode register, presents a byte and pulses the load strobe while the block is idle. The block then sends a low start bit and the data bits LSB first. After that comes either the marker bit (taken from the marker input at load time) or the parity bit, and then the stop bits. The line idles high. `tx_busy` is high for the whole frame, and `tx_done` pulses for one cycle when the frame ends. A mode write that arrives during a frame is held and takes effect when the frame ends. Selecting synchronous mode raises an unsupported flag, and the block then refuses to transmit.

The state machine has six states. IDLE moves to START on an accepted load. START moves to DATA when its bit period ends. DATA moves to MPB, PARITY or STOP after its last data bit, choosing in that order of preference. PARITY and MPB each move to STOP when their bit period ends. STOP moves to IDLE after its last stop bit, and that transition produces the done pulse.

Top module: `ser_tx_frame`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_busy` is 0, `tx_done` is 0 and `sync_err` is 0. The mode register holds 0x00, which selects 8 data bits, no parity, one stop bit, no marker bit and prescale 1.
- R2: An accepted frame starts with one low start bit, followed by the data bits LSB first. The line is 1 whenever the block is idle.
- R3: Mode bit 6 = 1 selects 7 data bits: only data[6:0] are sent and data[7] never appears on the line. Mode bit 6 = 0 sends all 8 bits.
- R4: Mode bit 5 = 1 appends one parity bit after the data bits. Mode bit 4 = 0 makes the count of ones in the sent data bits plus the parity bit even, and 1 makes it odd.
- R5: Mode bit 3 = 0 ends the frame with one high stop bit, and 1 ends it with two.
- R6: Mode bit 2 = 1 appends the value of `mpb_in` sampled at load, placed after the data bits. It replaces the parity bit even when mode bit 5 = 1.
- R7: Mode bits 1:0 = 00/01/10/11 select prescale P = 1/4/16/64. Every bit lasts exactly (`baud_div` + 1) × P clock cycles.
- R8: A load pulse while `tx_busy` is 1 is ignored: the current frame is unchanged, and no second frame follows.
- R9: For a frame of K bits lasting N cycles each, with the load accepted at clock edge 0, `tx_busy` falls and `tx_done` is high for exactly one cycle starting at edge K×N.
- R10: A mode write while `tx_busy` is 1 does not change the frame in progress. It takes effect at the end of that frame (the last write wins), and the next frame uses it.
- R11: Mode bit 7 = 1 (synchronous mode) drives `sync_err` to 1. While it is set, load pulses are ignored and `tx_line` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| baud_div | input | 16 | Bit period minus one, in prescaled ticks |
| tx_data | input | 8 | Byte to send, sampled on accepted load |
| tx_load | input | 1 | Load strobe, accepted only when idle and asynchronous |
| mpb_in | input | 1 | Marker bit value, sampled on accepted load |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle pulse at frame end |
| sync_err | output | 1 | Synchronous mode selected (unsupported) |

## Verification
The bench counts cycles from the clock edge that accepts a load, which it calls edge 0. Bit b occupies the cycles between edges b×N and (b+1)×N. The bench samples the line on the falling edge halfway through each bit. It expects `tx_busy` still high just before edge K×N, `tx_done` high with `tx_busy` low just after edge K×N, and `tx_done` low again one cycle later. A mode write takes effect at the following edge, so the unsupported flag is checked on the next falling edge. A deferred write is checked through the format of the frame that follows.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_MPB,
        ST_STOP
    } txf_state_e;

    // Field positions are fixed: bit 7 down to bit 0
    typedef struct packed {
        logic       sync_sel;
        logic       len7;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
        logic       mp_en;
        logic [1:0] cks;
    } txf_mode_t;

endpackage

// File: rtl/txf_prescaler.sv
module txf_prescaler #(
    parameter int STEP_LOG2 = 2,
    parameter int CODE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CODE_W-1:0] cks,
    output logic              tick
);
    localparam int PW = STEP_LOG2 * ((1 << CODE_W) - 1) + 1;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = (PW'(1) << (STEP_LOG2 * int'(cks))) - PW'(1);
        tick  = (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + PW'(1);
    end
endmodule

// File: rtl/txf_bit_timer.sv
module txf_bit_timer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [DW-1:0] div,
    output logic          bit_end
);
    logic [DW-1:0] cnt_q;

    assign bit_end = tick && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (bit_end) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + DW'(1);
    end
endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
    import txf_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DATA_W    = 8,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [7:0]        mode_wdata,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              mpb_in,
    output logic              tx_line,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              sync_err
);
    localparam int CNT_W = $clog2(DATA_W);

    txf_state_e        state_q, nxt;
    txf_mode_t         mode_q, pend_q;
    logic              pend_v;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  data_cnt;
    logic              stop_cnt;
    logic              par_q, mpb_q, done_q;
    logic              accept, bit_end, tick, frame_end;
    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W-1:0] masked;

    assign accept    = tx_load && (state_q == ST_IDLE) && !mode_q.sync_sel;
    assign last_idx  = mode_q.len7 ? CNT_W'(DATA_W - 2) : CNT_W'(DATA_W - 1);
    assign frame_end = (state_q == ST_STOP) && (nxt == ST_IDLE);
    assign masked    = mode_q.len7 ? {1'b0, tx_data[DATA_W-2:0]} : tx_data;

    txf_prescaler #(.STEP_LOG2(STEP_LOG2), .CODE_W(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(accept), .cks(mode_q.cks), .tick(tick)
    );

    txf_bit_timer #(.DW(DIV_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick),
        .div(baud_div), .bit_end(bit_end)
    );

    // Next-state decode
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) nxt = ST_START;
            ST_START:  if (bit_end) nxt = ST_DATA;
            ST_DATA:   if (bit_end && data_cnt == last_idx) begin
                           if (mode_q.mp_en)       nxt = ST_MPB;
                           else if (mode_q.par_en) nxt = ST_PARITY;
                           else                    nxt = ST_STOP;
                       end
            ST_PARITY: if (bit_end) nxt = ST_STOP;
            ST_MPB:    if (bit_end) nxt = ST_STOP;
            ST_STOP:   if (bit_end && (stop_cnt == mode_q.stop2)) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Frame datapath and mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            pend_q   <= '0;
            pend_v   <= 1'b0;
            shreg    <= '0;
            data_cnt <= '0;
            stop_cnt <= 1'b0;
            par_q    <= 1'b0;
            mpb_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (accept) begin
                shreg    <= masked;
                par_q    <= (^masked) ^ mode_q.par_odd;
                mpb_q    <= mpb_in;
                data_cnt <= '0;
                stop_cnt <= 1'b0;
            end else if (bit_end && state_q == ST_DATA) begin
                shreg    <= shreg >> 1;
                data_cnt <= data_cnt + CNT_W'(1);
            end else if (bit_end && state_q == ST_STOP) begin
                stop_cnt <= 1'b1;
            end
            if (frame_end) begin
                if (mode_we)     mode_q <= txf_mode_t'(mode_wdata);
                else if (pend_v) mode_q <= pend_q;
                pend_v <= 1'b0;
            end else if (mode_we) begin
                if (state_q == ST_IDLE && !accept) begin
                    mode_q <= txf_mode_t'(mode_wdata);
                end else begin
                    pend_q <= txf_mode_t'(mode_wdata);
                    pend_v <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   tx_line = 1'b1;
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg[0];
            ST_PARITY: tx_line = par_q;
            ST_MPB:    tx_line = mpb_q;
            ST_STOP:   tx_line = 1'b1;
            default:   tx_line = 1'b1;
        endcase
        tx_busy  = (state_q != ST_IDLE);
        tx_done  = done_q;
        sync_err = mode_q.sync_sel;
    end
endmodule

// File: rtl/ser_tx_frame_chk.sv
module ser_tx_frame_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_line,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       sync_err,
    input logic [7:0] mode_q
);
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_line);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_busy && $past(tx_busy)));

    assert_sync_no_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !tx_busy) |=> !tx_busy);

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(mode_q));
endmodule

bind ser_tx_frame ser_tx_frame_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .tx_busy(tx_busy),
    .tx_done(tx_done), .sync_err(sync_err), .mode_q(mode_q)
);

// File: tb/ser_tx_frame_tb.sv
module ser_tx_frame_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic [15:0] baud_div = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_load = 1'b0;
    logic        mpb_in = 1'b0;
    logic        tx_line, tx_busy, tx_done, sync_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model_mode = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_tx_frame u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .baud_div(baud_div), .tx_data(tx_data), .tx_load(tx_load), .mpb_in(mpb_in),
        .tx_line(tx_line), .tx_busy(tx_busy), .tx_done(tx_done), .sync_err(sync_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int build(input logic [7:0] m, input logic [7:0] d, input logic mp,
                                 output logic [15:0] bits);
        int n = 0;
        int dl = m[6] ? 7 : 8;
        logic [7:0] md = m[6] ? {1'b0, d[6:0]} : d;
        bits = '1;
        bits[n] = 1'b0; n = n + 1;
        for (int i = 0; i < dl; i++) begin bits[n] = md[i]; n = n + 1; end
        if (m[2])      begin bits[n] = mp; n = n + 1; end
        else if (m[5]) begin bits[n] = (^md) ^ m[4]; n = n + 1; end
        bits[n] = 1'b1; n = n + 1;
        if (m[3]) begin bits[n] = 1'b1; n = n + 1; end
        return n;
    endfunction

    task automatic write_mode(input logic [7:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wdata = m;
        @(negedge clk); mode_we = 1'b0;
        model_mode = m;
    endtask

    task automatic send(input string tag, input logic [7:0] d, input logic mp, input logic [15:0] div,
                        input bit poke_load, input bit poke_mode, input logic [7:0] new_mode);
        logic [15:0] exp_bits, obs;
        int k_bits = build(model_mode, d, mp, exp_bits);
        int n_cyc  = (int'(div) + 1) * (1 << (2 * int'(model_mode[1:0])));
        obs = '1;
        @(negedge clk); baud_div = div; tx_data = d; mpb_in = mp; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        for (int k = 0; k <= k_bits * n_cyc + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (poke_load) begin
                tx_load = (k == n_cyc);
                if (k == n_cyc) begin tx_data = ~d; mpb_in = ~mp; end
            end
            if (poke_mode) begin mode_we = (k == 1); mode_wdata = new_mode; end
            if ((k % n_cyc) == (n_cyc / 2) && (k / n_cyc) < k_bits) obs[k / n_cyc] = tx_line;
            if (k == k_bits * n_cyc - 1)
                check(tx_busy && !tx_done, {tag, " R9 busy before end"}, {tx_busy, tx_done}, 2'b10);
            if (k == k_bits * n_cyc)
                check(tx_done && !tx_busy && tx_line, {tag, " R9 done at end"},
                      {tx_done, tx_busy, tx_line}, 3'b101);
            if (k == k_bits * n_cyc + 1)
                check(!tx_done && !tx_busy, {tag, " R9/R8 quiet after"}, {tx_done, tx_busy}, 2'b00);
        end
        check(obs == exp_bits, {tag, " frame bits"}, obs, exp_bits);
        if (poke_mode) model_mode = new_mode;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] rm;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_line == 1'b1, "R1 line", tx_line, 1);
        check(tx_busy == 1'b0, "R1 busy", tx_busy, 0);
        check(tx_done == 1'b0, "R1 done", tx_done, 0);
        check(sync_err == 1'b0, "R1 sync_err", sync_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line && !tx_busy, "R1 after release", {tx_line, tx_busy}, 2'b10);
        // R1 default format and R2 order
        send("R1/R2 default 8N1", 8'hA5, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        send("R2 lsb first", 8'h01, 1'b0, 16'd0, 1'b0, 1'b0, 8'h00);
        // R3 seven bit drops data[7]
        write_mode(8'h40);
        send("R3 7-bit", 8'hFF, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        send("R3 7-bit msb only", 8'h80, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        // R4 parity
        write_mode(8'h20);
        send("R4 even", 8'h07, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        write_mode(8'h30);
        send("R4 odd", 8'h07, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        write_mode(8'h70);
        send("R4 odd 7-bit", 8'h81, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        // R5 two stop bits
        write_mode(8'h08);
        send("R5 two stop", 8'h3C, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        // R6 marker over parity
        write_mode(8'h24);
        send("R6 marker=1", 8'h00, 1'b1, 16'd1, 1'b0, 1'b0, 8'h00);
        send("R6 marker=0", 8'h01, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        // R7 prescaler
        write_mode(8'h03);
        send("R7 P64", 8'h5A, 1'b0, 16'd0, 1'b0, 1'b0, 8'h00);
        write_mode(8'h01);
        send("R7 P4 div3", 8'hC3, 1'b0, 16'd3, 1'b0, 1'b0, 8'h00);
        write_mode(8'h02);
        send("R7 P16", 8'h96, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        // R8 load while busy
        write_mode(8'h00);
        send("R8 load ignored", 8'h6E, 1'b0, 16'd2, 1'b1, 1'b0, 8'h00);
        // R10 deferred mode write
        send("R10 old format kept", 8'h9B, 1'b0, 16'd1, 1'b0, 1'b1, 8'h28);
        send("R10 new format used", 8'h9B, 1'b0, 16'd1, 1'b0, 1'b0, 8'h00);
        // R11 synchronous mode
        write_mode(8'h80);
        check(sync_err == 1'b1, "R11 flag", sync_err, 1);
        @(negedge clk); tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (tx_busy || !tx_line) begin
                check(1'b0, "R11 no transmit", {tx_busy, tx_line}, 2'b01);
                break;
            end
            @(negedge clk);
        end
        check(!tx_busy && tx_line, "R11 idle", {tx_busy, tx_line}, 2'b01);
        write_mode(8'h00);
        check(sync_err == 1'b0, "R11 flag cleared", sync_err, 0);
        // random frames across R2..R7
        for (int i = 0; i < 16; i++) begin
            rm = {1'b0, 7'($urandom)};
            write_mode(rm);
            send("R2-7 random", 8'($urandom), 1'($urandom), 16'($urandom_range(0, 2)),
                 1'b0, 1'b0, 8'h00);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule